// File: doc/BRIEF.md
# DMA Channel Control Write Gate

This block owns the 32-bit control word of each channel in a DMA engine. It decides how much of a software write reaches that word. Three things decide it: whether the addressed channel is already running, whether the controller is held in suspend, and whether the controller is globally enabled. Each control word has a run bit, a two-bit transfer mode, other low control bits, and a 16-bit tag in its upper half.

Writes that stop a running channel have side effects. They fire one-cycle clear strobes at the interrupt sources of that channel and remove any start that was waiting for it. Two channels also own a second interrupt source. Writes that launch a channel either pulse its start output at once or park it in a 16-bit pending-start mask. When the controller is enabled and not suspended, that mask drains one channel per cycle, lowest index first.

Top module: `dmag_ctrl_gate`

## Requirements
- R1: The control word has the run bit at bit 8, the mode in bits 3:2 and the tag in bits 31:16. A write to a channel whose run bit is 0 loads all 32 data bits into the word, one cycle after the write is presented.
- R2: A write to a running channel while `ctrl_suspend` is 0 and data bit 8 is 1 leaves that word unchanged.
- R3: A write to a running channel while `ctrl_suspend` is 0 and data bit 8 is 0 clears only bit 8. Every other bit of the word is kept.
- R4: A write to a running channel while `ctrl_suspend` is 1 replaces bits 15:0 with the data and keeps bits 31:16.
- R5: A write with data bit 8 at 0 to a running channel, suspended or not, does two things in the next cycle: it pulses `irq_clear` bit c for one cycle, and it clears `queued_mask` bit c, where c is the channel.
- R6: Stopping channel 1 also pulses `irq_clear[10]` and clears `queued_mask[10]`. Stopping channel 2 does the same with bit 11.
- R7: On a write to a channel that is not running, a mode field of 3 is stored as 1.
- R8: A write to a channel that is not running, with data bit 8 at 1, while `ctrl_enable` is 1 and `ctrl_suspend` is 0, pulses `start_pulse[c]` for one cycle in the next cycle.
- R9: The same write while `ctrl_enable` is 0 or `ctrl_suspend` is 1 sets `queued_mask[c]` and gives no start pulse.
- R10: In every cycle where `ctrl_enable` is 1 and `ctrl_suspend` is 0, the lowest-index channel bit set in the mask (after that cycle's write) is cleared, and its start pulse is issued in the next cycle. At most one channel is drained per cycle.
- R11: Reset clears all control words, `queued_mask`, `start_pulse` and `irq_clear`.
- R12: A write whose channel index is NUM_CH or above changes no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Single-cycle write strobe |
| wr_chan | input | CH_W | Channel addressed by the write |
| wr_data | input | 32 | Write data |
| ctrl_enable | input | 1 | Global controller enable |
| ctrl_suspend | input | 1 | Controller suspend |
| chan_ctrl | output | NUM_CH*32 | All control words, channel c at bits c*32 +: 32 |
| start_pulse | output | NUM_CH | One-cycle channel start strobes |
| queued_mask | output | 16 | Pending-start mask |
| irq_clear | output | 16 | One-cycle interrupt-source clear strobes |

## Verification
Two things can fall in the same cycle. A direct start comes from a write to an idle channel. A drained start comes from the pending mask. The bench raises the enable in the very cycle in which it writes a launch to another channel, and it expects two start bits side by side.

A second collision is a stop written to a queued channel in the cycle the drain begins. Here the bench expects the drain to skip that channel and issue the next queued one. A behavioural model predicts every output on every clock, and each mismatch is judged against that model.

// File: rtl/dmag_pkg.sv
package dmag_pkg;
    localparam int WORD_W     = 32;
    localparam int RUN_BIT    = 8;
    localparam int MODE_LO    = 2;
    localparam int MODE_W     = 2;
    localparam int TAG_LO     = 16;
    localparam int MASK_W     = 16;
    localparam int PAIR_CH_A  = 1;
    localparam int PAIR_SRC_A = 10;
    localparam int PAIR_CH_B  = 2;
    localparam int PAIR_SRC_B = 11;
    localparam logic [MODE_W-1:0] MODE_ILLEGAL = 2'd3;
    localparam logic [MODE_W-1:0] MODE_CHAIN   = 2'd1;

    typedef struct packed {
        logic              load;
        logic [WORD_W-1:0] value;
        logic              start_now;
        logic [MASK_W-1:0] set_mask;
        logic [MASK_W-1:0] clr_mask;
        logic [MASK_W-1:0] chan_hot;
    } wr_action_t;
endpackage

// File: rtl/dmag_write_decode.sv
module dmag_write_decode
    import dmag_pkg::*;
#(
    parameter int NUM_CH = 10,
    localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic              wr_valid,
    input  logic [CH_W-1:0]   wr_chan,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [WORD_W-1:0] cur_ctrl,
    input  logic              ctrl_enable,
    input  logic              ctrl_suspend,
    output wr_action_t        act
);
    logic in_range;
    logic running;
    logic [MASK_W-1:0] hot;
    logic [MASK_W-1:0] stop_mask;

    assign in_range = int'(wr_chan) < NUM_CH;
    assign running  = cur_ctrl[RUN_BIT];
    assign hot      = MASK_W'(1) << wr_chan;

    always_comb begin
        stop_mask = hot;
        if (wr_chan == CH_W'(PAIR_CH_A)) stop_mask[PAIR_SRC_A] = 1'b1;
        if (wr_chan == CH_W'(PAIR_CH_B)) stop_mask[PAIR_SRC_B] = 1'b1;
    end

    always_comb begin
        act           = '0;
        act.chan_hot  = hot;
        act.value     = cur_ctrl;
        if (wr_valid && in_range) begin
            if (running) begin
                if (!wr_data[RUN_BIT]) act.clr_mask = stop_mask;
                if (ctrl_suspend) begin
                    act.load  = 1'b1;
                    act.value = {cur_ctrl[WORD_W-1:TAG_LO], wr_data[TAG_LO-1:0]};
                end else if (!wr_data[RUN_BIT]) begin
                    act.load           = 1'b1;
                    act.value[RUN_BIT] = 1'b0;
                end
            end else begin
                act.load  = 1'b1;
                act.value = wr_data;
                if (wr_data[MODE_LO +: MODE_W] == MODE_ILLEGAL)
                    act.value[MODE_LO +: MODE_W] = MODE_CHAIN;
                if (wr_data[RUN_BIT]) begin
                    if (ctrl_enable && !ctrl_suspend) act.start_now = 1'b1;
                    else                              act.set_mask  = hot;
                end
            end
        end
    end
endmodule

// File: rtl/dmag_low_pick.sv
module dmag_low_pick #(
    parameter int W = 10
) (
    input  logic [W-1:0] req,
    output logic [W-1:0] grant
);
    logic [W:0] seen;
    assign seen[0] = 1'b0;

    for (genvar i = 0; i < W; i++) begin : g_bit
        assign grant[i]  = req[i] & ~seen[i];
        assign seen[i+1] = seen[i] | req[i];
    end
endmodule

// File: rtl/dmag_ctrl_gate.sv
module dmag_ctrl_gate
    import dmag_pkg::*;
#(
    parameter int NUM_CH = 10,
    localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_valid,
    input  logic [CH_W-1:0]          wr_chan,
    input  logic [31:0]              wr_data,
    input  logic                     ctrl_enable,
    input  logic                     ctrl_suspend,
    output logic [NUM_CH*32-1:0]     chan_ctrl,
    output logic [NUM_CH-1:0]        start_pulse,
    output logic [15:0]              queued_mask,
    output logic [15:0]              irq_clear
);
    typedef struct packed {
        logic [NUM_CH-1:0][WORD_W-1:0] ctrl;
        logic [MASK_W-1:0]             queued;
        logic [NUM_CH-1:0]             start;
        logic [MASK_W-1:0]             irqclr;
    } gate_state_t;

    gate_state_t st_d, st_q;
    wr_action_t  act;
    logic [WORD_W-1:0] cur_ctrl;
    logic [MASK_W-1:0] q_after;
    logic [NUM_CH-1:0] drain_req;
    logic [NUM_CH-1:0] drain_grant;
    logic              drain_ok;

    assign cur_ctrl = (int'(wr_chan) < NUM_CH) ? st_q.ctrl[wr_chan] : '0;

    dmag_write_decode #(.NUM_CH(NUM_CH)) u_decode (
        .wr_valid    (wr_valid),
        .wr_chan     (wr_chan),
        .wr_data     (wr_data),
        .cur_ctrl    (cur_ctrl),
        .ctrl_enable (ctrl_enable),
        .ctrl_suspend(ctrl_suspend),
        .act         (act)
    );

    assign drain_ok  = ctrl_enable && !ctrl_suspend;
    assign q_after   = (st_q.queued & ~act.clr_mask) | act.set_mask;
    assign drain_req = drain_ok ? q_after[NUM_CH-1:0] : '0;

    dmag_low_pick #(.W(NUM_CH)) u_pick (
        .req  (drain_req),
        .grant(drain_grant)
    );

    always_comb begin
        st_d        = st_q;
        st_d.irqclr = act.clr_mask;
        st_d.queued = q_after & ~MASK_W'(drain_grant);
        st_d.start  = drain_grant;
        if (act.start_now) st_d.start = st_d.start | act.chan_hot[NUM_CH-1:0];
        if (act.load)      st_d.ctrl[wr_chan] = act.value;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign chan_ctrl   = st_q.ctrl;
    assign start_pulse = st_q.start;
    assign queued_mask = st_q.queued;
    assign irq_clear   = st_q.irqclr;
endmodule

// File: rtl/dmag_gate_checker.sv
module dmag_gate_checker #(
    parameter int NUM_CH = 10,
    localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 wr_valid,
    input logic [CH_W-1:0]      wr_chan,
    input logic [31:0]          wr_data,
    input logic                 ctrl_enable,
    input logic                 ctrl_suspend,
    input logic [NUM_CH*32-1:0] chan_ctrl,
    input logic [NUM_CH-1:0]    start_pulse,
    input logic [15:0]          queued_mask,
    input logic [15:0]          irq_clear
);
    for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
        logic hit;
        logic run;
        assign hit = wr_valid && (int'(wr_chan) == k);
        assign run = chan_ctrl[k*32 + 8];

        // R2
        r2_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            hit && run && !ctrl_suspend && wr_data[8] |=> $stable(chan_ctrl[k*32 +: 32]));
        // R5
        r5_stop_purge_chk: assert property (@(posedge clk) disable iff (!rst_n)
            hit && run && !wr_data[8] |=> irq_clear[k] && !queued_mask[k]);
        // R8
        r8_direct_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
            hit && !run && wr_data[8] && ctrl_enable && !ctrl_suspend |=> start_pulse[k]);
        // R9
        r9_queued_running_chk: assert property (@(posedge clk) disable iff (!rst_n)
            queued_mask[k] |-> run);
        // R7
        r7_mode_remap_chk: assert property (@(posedge clk) disable iff (!rst_n)
            hit && !run |=> chan_ctrl[k*32 + 2 +: 2] != 2'd3);
    end

    // R6
    r6_pair_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_clear[10] |-> $past(wr_valid) && $past(wr_chan) == CH_W'(1));
    // R10
    r10_drain_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(start_pulse) <= 2);
endmodule

bind dmag_ctrl_gate dmag_gate_checker #(.NUM_CH(NUM_CH)) u_gate_chk (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_chan(wr_chan),
    .wr_data(wr_data), .ctrl_enable(ctrl_enable), .ctrl_suspend(ctrl_suspend),
    .chan_ctrl(chan_ctrl), .start_pulse(start_pulse), .queued_mask(queued_mask),
    .irq_clear(irq_clear)
);

// File: tb/test_dmag_ctrl_gate.sv
module test_dmag_ctrl_gate;
    localparam int NUM_CH = 10;
    localparam int CH_W = $clog2(NUM_CH);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_valid = 1'b0;
    logic [CH_W-1:0] wr_chan = '0;
    logic [31:0] wr_data = '0;
    logic ctrl_enable = 1'b0;
    logic ctrl_suspend = 1'b0;
    logic [NUM_CH*32-1:0] chan_ctrl;
    logic [NUM_CH-1:0] start_pulse;
    logic [15:0] queued_mask;
    logic [15:0] irq_clear;

    always #10 clk = ~clk;

    dmag_ctrl_gate #(.NUM_CH(NUM_CH)) i_dmag_ctrl_gate (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_chan(wr_chan),
        .wr_data(wr_data), .ctrl_enable(ctrl_enable), .ctrl_suspend(ctrl_suspend),
        .chan_ctrl(chan_ctrl), .start_pulse(start_pulse), .queued_mask(queued_mask),
        .irq_clear(irq_clear)
    );

    int checks = 0;
    int fails = 0;
    string cur_req = "R11";
    bit finished = 0;

    logic [31:0] m_ctrl [NUM_CH];
    logic [15:0] m_q = '0;
    logic [NUM_CH-1:0] m_start = '0;
    logic [15:0] m_irq = '0;

    initial for (int i = 0; i < NUM_CH; i++) m_ctrl[i] = '0;

    // behavioural reference model
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_CH; i++) m_ctrl[i] = '0;
            m_q = '0; m_start = '0; m_irq = '0;
        end else begin
            m_start = '0;
            m_irq = '0;
            if (wr_valid && int'(wr_chan) < NUM_CH) begin
                int ch;
                logic [31:0] old, v;
                ch = int'(wr_chan);
                old = m_ctrl[ch];
                if (old[8] == 1'b1) begin
                    if (wr_data[8] == 1'b0) begin
                        m_irq[ch] = 1'b1; m_q[ch] = 1'b0;
                        if (ch == 1) begin m_irq[10] = 1'b1; m_q[10] = 1'b0; end
                        if (ch == 2) begin m_irq[11] = 1'b1; m_q[11] = 1'b0; end
                    end
                    if (ctrl_suspend) m_ctrl[ch] = {old[31:16], wr_data[15:0]};
                    else if (wr_data[8] == 1'b0) m_ctrl[ch] = old & 32'hFFFF_FEFF;
                end else begin
                    v = wr_data;
                    if (v[3:2] == 2'd3) v[3:2] = 2'd1;
                    m_ctrl[ch] = v;
                    if (v[8]) begin
                        if (ctrl_enable && !ctrl_suspend) m_start[ch] = 1'b1;
                        else m_q[ch] = 1'b1;
                    end
                end
            end
            if (ctrl_enable && !ctrl_suspend) begin
                for (int i = 0; i < NUM_CH; i++) begin
                    if (m_q[i]) begin
                        m_start[i] = 1'b1;
                        m_q[i] = 1'b0;
                        break;
                    end
                end
            end
        end
    end

    task automatic check(input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", cur_req, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!finished) begin
            for (int i = 0; i < NUM_CH; i++)
                check($sformatf("ctrl[%0d]", i), 64'(chan_ctrl[i*32 +: 32]), 64'(m_ctrl[i]));
            check("queued_mask", 64'(queued_mask), 64'(m_q));
            check("start_pulse", 64'(start_pulse), 64'(m_start));
            check("irq_clear", 64'(irq_clear), 64'(m_irq));
        end
    end

    task automatic wr(input int ch, input logic [31:0] d);
        @(negedge clk);
        wr_valid = 1'b1; wr_chan = CH_W'(ch); wr_data = d;
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run;
        finished = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    int wd = 0;
    always @(posedge clk) begin
        wd++;
        if (wd > 20000 && !finished) begin
            checks++; fails++;
            $display("FAIL watchdog: actual hung expected done");
            finish_run();
        end
    end

    initial begin
        cur_req = "R11";
        idle(3);
        rst_n = 1'b1;
        ctrl_enable = 1'b1;
        idle(2);

        cur_req = "R1";
        wr(0, 32'hABCD_0004);
        cur_req = "R7";
        wr(3, 32'h1234_000C);
        cur_req = "R8";
        wr(4, 32'h5555_0105);
        cur_req = "R2";
        wr(4, 32'hFFFF_FFFF);
        cur_req = "R3";
        wr(4, 32'h0000_0000);
        cur_req = "R5";
        idle(1);

        cur_req = "R9";
        ctrl_enable = 1'b0;
        wr(5, 32'h0000_0100);
        wr(6, 32'h7777_010C);
        wr(1, 32'h0000_0100);
        idle(2);

        // enable rises in the same cycle as a direct start on channel 7
        cur_req = "R10";
        @(negedge clk);
        ctrl_enable = 1'b1;
        wr_valid = 1'b1; wr_chan = CH_W'(7); wr_data = 32'h3333_0100;
        @(negedge clk);
        wr_valid = 1'b0;
        idle(4);

        cur_req = "R4";
        ctrl_suspend = 1'b1;
        wr(7, 32'h9999_0F1C);
        cur_req = "R6";
        wr(2, 32'h0000_0100);
        wr(2, 32'h0000_0000);
        ctrl_suspend = 1'b0;
        wr(1, 32'h0000_0000);
        idle(1);

        // stop a queued channel in the cycle the drain begins
        cur_req = "R10";
        ctrl_enable = 1'b0;
        wr(8, 32'h0000_0100);
        wr(9, 32'h0000_0100);
        @(negedge clk);
        ctrl_enable = 1'b1;
        wr_valid = 1'b1; wr_chan = CH_W'(8); wr_data = 32'h0000_0000;
        @(negedge clk);
        wr_valid = 1'b0;
        idle(3);

        cur_req = "R12";
        wr(12, 32'hFFFF_FFFF);
        wr(15, 32'h0000_0100);
        idle(2);

        cur_req = "R11";
        rst_n = 1'b0;
        idle(2);
        finish_run();
    end
endmodule